// File: doc/BRIEF.md
# Second-Order Phase Accumulator

This block produces one phase value per input sample for a quadrature mixer that sits in front of a polyphase filter bank. The phase follows a quadratic in the sample index, p0 + p1·n + p2·n². It is built from two nested adders and uses no multiplier. The inner accumulator sums p2. The outer accumulator adds p1 + p2 + 2·inner on every sample, which gives the quadratic exactly.

A start strobe captures the three coefficients and restarts the polynomial at n = 0. Every accumulator wraps modulo 2^W, so full scale is one turn. A slip request from the delay model moves the phase by a quarter turn, either forward or backward. The mixer receives the top OW bits of the phase, registered, one cycle after each sample strobe. The full-width phase is also provided beside it.

Top module: `phase_quad_acc`

## Requirements
- R1: While reset is held and afterwards until the first strobe, `phase_vld_o` is 0 and `phase_word_o` and `phase_full_o` are 0.
- R2: A cycle with `start_i` high captures `p1_i` and `p2_i`, sets the phase to `p0_i` and clears the inner sum. The first sample after it therefore reports exactly `p0_i`.
- R3: Sample number n after a start (n = 0, 1, 2, …), with no slips, reports a full phase of p0 + p1·n + p2·n² modulo 2^W.
- R4: A sample strobe in cycle k makes `phase_vld_o` high for exactly cycle k+1. In that cycle `phase_full_o` is the phase before this sample's update, and `phase_word_o` equals bits [W-1:W-OW] of that phase.
- R5: Every sum wraps modulo 2^W without saturation. A polynomial that passes full scale continues from the wrapped value.
- R6: A slip request with `slip_dir_i` = 0 adds 2^(W-2) to the phase. With `slip_dir_i` = 1 it subtracts 2^(W-2). The offset applies to every later sample of the integration.
- R7: A slip in the same cycle as a sample strobe does not change that sample's reported phase. Both the sample step and the quarter turn apply to the next sample.
- R8: `start_i` has priority. A sample strobe or slip in the same cycle as `start_i` is dropped: no valid output follows, and the next sample reports `p0_i`.
- R9: Coefficient inputs that change without `start_i` have no effect. Cycles with no strobe leave the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Integration start: capture coefficients and restart at n = 0 |
| p0_i | input | W | Constant phase term |
| p1_i | input | W | Linear phase term |
| p2_i | input | W | Quadratic phase term |
| smp_vld_i | input | 1 | One sample per high cycle |
| slip_vld_i | input | 1 | Quarter-turn correction request |
| slip_dir_i | input | 1 | 0 = add a quarter turn, 1 = subtract it |
| phase_word_o | output | OW | Truncated phase for the mixer lookup |
| phase_full_o | output | W | Full-width phase of the reported sample |
| phase_vld_o | output | 1 | Output valid, one cycle after the sample strobe |

## Verification
The assertions assume the strobes are synchronous single-cycle levels, with no ordering between them. Any of start, sample and slip may be high together, and the checks take that overlap into account rather than ruling it out. The stimulus drives these strobes alone, back to back, with idle gaps, and together with each other, including start together with a sample and a slip. The coefficient values are chosen so that the quadratic passes full scale within a short integration.

// File: rtl/phacc_pkg.sv
package phacc_pkg;

    // Direction of a quarter-turn slip request
    typedef enum logic {
        SLIP_ADVANCE = 1'b0,
        SLIP_RETARD  = 1'b1
    } slip_dir_e;

endpackage

// File: rtl/phacc_coef.sv
module phacc_coef #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] p1_i,
    input  logic [W-1:0] p2_i,
    output logic [W-1:0] p1_o,
    output logic [W-1:0] p2_o
);

    typedef struct packed {
        logic [W-1:0] p1;
        logic [W-1:0] p2;
    } coef_t;

    coef_t coef_d, coef_q;

    always_comb begin
        coef_d = coef_q;
        if (load_i) begin
            coef_d.p1 = p1_i;
            coef_d.p2 = p2_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coef_q <= '0;
        else        coef_q <= coef_d;
    end

    assign p1_o = coef_q.p1;
    assign p2_o = coef_q.p2;

endmodule

// File: rtl/phacc_core.sv
module phacc_core
    import phacc_pkg::*;
#(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] p0_i,
    input  logic [W-1:0] p1_i,
    input  logic [W-1:0] p2_i,
    input  logic         step_i,
    input  logic         slip_i,
    input  logic         slip_dir_i,
    output logic [W-1:0] phase_o,
    output logic [W-1:0] inner_o
);

    localparam logic [W-1:0] QUARTER = {2'b01, {(W-2){1'b0}}};

    typedef struct packed {
        logic [W-1:0] phase;
        logic [W-1:0] inner;
    } acc_t;

    acc_t         acc_d, acc_q;
    logic [W-1:0] step_delta;
    logic [W-1:0] slip_delta;
    slip_dir_e    dir;

    assign dir = slip_dir_e'(slip_dir_i);

    always_comb begin
        acc_d      = acc_q;
        step_delta = '0;
        slip_delta = '0;
        if (start_i) begin
            acc_d.phase = p0_i;
            acc_d.inner = '0;
        end else begin
            if (step_i) begin
                // first difference of the quadratic: p1 + p2 + 2*inner
                step_delta  = p1_i + p2_i + {acc_q.inner[W-2:0], 1'b0};
                acc_d.inner = acc_q.inner + p2_i;
            end
            if (slip_i) begin
                slip_delta = (dir == SLIP_RETARD) ? (~QUARTER + 1'b1) : QUARTER;
            end
            acc_d.phase = acc_q.phase + step_delta + slip_delta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign phase_o = acc_q.phase;
    assign inner_o = acc_q.inner;

endmodule

// File: rtl/phacc_outreg.sv
module phacc_outreg #(
    parameter int W  = 48,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [W-1:0]  phase_i,
    output logic [OW-1:0] word_o,
    output logic [W-1:0]  full_o,
    output logic          vld_o
);

    typedef struct packed {
        logic [OW-1:0] word;
        logic [W-1:0]  full;
        logic          vld;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = step_i;
        if (step_i) begin
            out_d.word = phase_i[W-1 -: OW];
            out_d.full = phase_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign word_o = out_q.word;
    assign full_o = out_q.full;
    assign vld_o  = out_q.vld;

endmodule

// File: rtl/phase_quad_acc.sv
module phase_quad_acc #(
    parameter int W  = 48,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [W-1:0]  p0_i,
    input  logic [W-1:0]  p1_i,
    input  logic [W-1:0]  p2_i,
    input  logic          smp_vld_i,
    input  logic          slip_vld_i,
    input  logic          slip_dir_i,
    output logic [OW-1:0] phase_word_o,
    output logic [W-1:0]  phase_full_o,
    output logic          phase_vld_o
);

    logic         step;
    logic         slip;
    logic [W-1:0] coef_p1;
    logic [W-1:0] coef_p2;
    logic [W-1:0] core_phase;
    logic [W-1:0] core_inner;

    // a start overrides any coincident sample or slip
    assign step = smp_vld_i  & ~start_i;
    assign slip = slip_vld_i & ~start_i;

    phacc_coef #(.W(W)) i_coef (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_i),
        .p1_i   (p1_i),
        .p2_i   (p2_i),
        .p1_o   (coef_p1),
        .p2_o   (coef_p2)
    );

    phacc_core #(.W(W)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .p0_i       (p0_i),
        .p1_i       (coef_p1),
        .p2_i       (coef_p2),
        .step_i     (step),
        .slip_i     (slip),
        .slip_dir_i (slip_dir_i),
        .phase_o    (core_phase),
        .inner_o    (core_inner)
    );

    phacc_outreg #(.W(W), .OW(OW)) i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .phase_i (core_phase),
        .word_o  (phase_word_o),
        .full_o  (phase_full_o),
        .vld_o   (phase_vld_o)
    );

endmodule

// File: rtl/phacc_chk.sv
module phacc_chk #(
    parameter int W  = 48,
    parameter int OW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [W-1:0]  p0_i,
    input logic          smp_vld_i,
    input logic          slip_vld_i,
    input logic          slip_dir_i,
    input logic [OW-1:0] phase_word_o,
    input logic [W-1:0]  phase_full_o,
    input logic          phase_vld_o,
    input logic [W-1:0]  coef_p1,
    input logic [W-1:0]  coef_p2,
    input logic [W-1:0]  core_phase,
    input logic [W-1:0]  core_inner
);

    localparam logic [W-1:0] QTR = {2'b01, {(W-2){1'b0}}};

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (core_phase == $past(p0_i)) && (core_inner == '0));

    // R3
    inner_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && !start_i) |=> core_inner == $past(core_inner) + $past(coef_p2));

    // R4
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && !start_i) |=> phase_vld_o);

    // R4
    vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld_i |=> !phase_vld_o);

    // R4
    word_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && !start_i) |=> phase_word_o == $past(core_phase[W-1 -: OW]));

    // R6
    slip_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_vld_i && !smp_vld_i && !start_i) |=>
            core_phase == ($past(slip_dir_i) ? $past(core_phase) - QTR
                                             : $past(core_phase) + QTR));

    // R8
    start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !phase_vld_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !smp_vld_i && !slip_vld_i) |=>
            $stable(core_phase) && $stable(core_inner));

    // R9
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(coef_p1) && $stable(coef_p2));

endmodule

bind phase_quad_acc phacc_chk #(.W(W), .OW(OW)) i_phacc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .p0_i         (p0_i),
    .smp_vld_i    (smp_vld_i),
    .slip_vld_i   (slip_vld_i),
    .slip_dir_i   (slip_dir_i),
    .phase_word_o (phase_word_o),
    .phase_full_o (phase_full_o),
    .phase_vld_o  (phase_vld_o),
    .coef_p1      (coef_p1),
    .coef_p2      (coef_p2),
    .core_phase   (core_phase),
    .core_inner   (core_inner)
);

// File: tb/test_phase_quad_acc.sv
module test_phase_quad_acc;

    localparam int W  = 48;
    localparam int OW = 16;
    localparam logic [W-1:0] QTR = {2'b01, {(W-2){1'b0}}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [W-1:0]  p0_i = '0, p1_i = '0, p2_i = '0;
    logic          smp_vld_i = 1'b0, slip_vld_i = 1'b0, slip_dir_i = 1'b0;
    logic [OW-1:0] phase_word_o;
    logic [W-1:0]  phase_full_o;
    logic          phase_vld_o;

    always #10 clk = ~clk;

    phase_quad_acc #(.W(W), .OW(OW)) i_phase_quad_acc (.*);

    typedef struct {
        logic [W-1:0] full;
        string        req;
    } item_t;

    item_t        sb[$];
    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] m_p0, m_p1, m_p2, m_n, m_off;
    bit           done = 0;

    // monitor: samples 5 ns after each rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n && phase_vld_o) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R4/R8: unexpected valid, actual full=%h expected none", phase_full_o);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (phase_full_o !== it.full || phase_word_o !== it.full[W-1 -: OW]) begin
                    errors++;
                    $display("FAIL %s: actual full=%h word=%h expected full=%h word=%h",
                             it.req, phase_full_o, phase_word_o, it.full, it.full[W-1 -: OW]);
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            start_i = 0; smp_vld_i = 0; slip_vld_i = 0;
        end
    endtask

    task automatic start(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, bit with_smp);
        @(negedge clk);
        start_i = 1; p0_i = a; p1_i = b; p2_i = c;
        smp_vld_i = with_smp; slip_vld_i = with_smp; slip_dir_i = 0;
        m_p0 = a; m_p1 = b; m_p2 = c; m_n = '0; m_off = '0;
    endtask

    task automatic sample(string req, bit slip, bit dir);
        item_t it;
        @(negedge clk);
        start_i = 0; smp_vld_i = 1; slip_vld_i = slip; slip_dir_i = dir;
        it.full = m_p0 + m_p1 * m_n + m_p2 * m_n * m_n + m_off;
        it.req  = req;
        sb.push_back(it);
        m_n = m_n + 1;
        if (slip) m_off = dir ? m_off - QTR : m_off + QTR;
    endtask

    task automatic slip_only(bit dir);
        @(negedge clk);
        start_i = 0; smp_vld_i = 0; slip_vld_i = 1; slip_dir_i = dir;
        m_off = dir ? m_off - QTR : m_off + QTR;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (phase_vld_o !== 0 || phase_word_o !== '0 || phase_full_o !== '0) begin
            errors++;
            $display("FAIL R1: actual vld=%b word=%h expected 0 0", phase_vld_o, phase_word_o);
        end
        rst_n = 1;
        idle(3);
        checks++;
        if (phase_vld_o !== 0 || phase_full_o !== '0) begin
            errors++;
            $display("FAIL R1: actual vld=%b full=%h after reset expected 0 0", phase_vld_o, phase_full_o);
        end

        // R2, R3: plain quadratic, back-to-back samples
        start(48'h0000_1234_5678, 48'h0000_0010_0000, 48'h0000_0000_0300, 0);
        sample("R2", 0, 0);
        for (int i = 0; i < 8; i++) sample("R3", 0, 0);
        idle(2);
        // R3 with gaps between samples; R9 idle holds state
        for (int i = 0; i < 4; i++) begin sample("R3", 0, 0); idle(3); end

        // R9: coefficient inputs change without start
        @(negedge clk); smp_vld_i = 0; p0_i = 48'hdead; p1_i = 48'h7777_0000_0000; p2_i = 48'h1;
        idle(2);
        for (int i = 0; i < 3; i++) sample("R9", 0, 0);

        // R5: wrap through full scale
        start(48'hFFFF_FFFF_F000, 48'h4000_0000_0123, 48'h0100_0000_0007, 0);
        for (int i = 0; i < 10; i++) sample("R5", 0, 0);

        // R6: standalone slips both ways
        start(48'h0, 48'h0000_0001_0000, 48'h0000_0000_0021, 0);
        sample("R6", 0, 0);
        slip_only(0);
        sample("R6", 0, 0);
        sample("R6", 0, 0);
        slip_only(1); slip_only(1);
        idle(1);
        sample("R6", 0, 0);
        sample("R6", 0, 0);

        // R7: slip coincident with a sample
        sample("R7", 1, 0);
        sample("R7", 0, 0);
        sample("R7", 1, 1);
        sample("R7", 0, 0);

        // R8: start with coincident sample and slip, dropped
        idle(1);
        start(48'h1111_2222_3333, 48'h0000_0000_0100, 48'h0000_0000_0001, 1);
        idle(2);
        sample("R8", 0, 0);
        sample("R8", 0, 0);
        idle(4);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R4: actual %0d outputs missing expected 0", sb.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule